// File: doc/BRIEF.md
# Deep-Stop Entry and Wakeup Sequencer

This block decides when the processor power domain drops into a deep stop state and when it comes back. It watches the core's wait strobes (wait-for-interrupt, wait-for-event, and return from an interrupt handler with sleep-on-exit armed). It checks the deep-sleep enable and a 3-bit mode select, and screens the request against pending interrupts, pending events and pending wakeup flags. It then either enters stop, enters a plain sleep with clocks running, ignores the request, or rejects it with a one-cycle abort pulse.

While in stop, the block gates the core-domain clocks and holds the oscillators off. The kind of wait that caused entry is latched, and it selects which wakeup lines may end the stop. On a wakeup hit the oscillators are re-enabled. The block then waits for two things: the oscillator ready, and regulator ready followed by flash ready. When both are seen it ungates clocks and pulses wakeup-done. All pins are plain control and status levels or strobes. There is no streaming data path, so no valid/ready back-pressure applies.

Top module: `lpc_ctrl`

## Requirements
- R1: After reset the block is running: `clk_stop_o`, `osc_off_o`, `sleep_o`, `wake_done_o` and `entry_abort_o` are all 0.
- R2: In run, a qualified request with `deep_en_i`=1 and `mode_sel_i`=3'b001, with nothing pending, sets `clk_stop_o` and `osc_off_o` to 1 in the cycle after the strobe.
- R3: `isr_ret_i` counts as a request only while `exit_sleep_en_i`=1; otherwise it is ignored.
- R4: A wait-for-interrupt or return-from-handler request is ignored (no state change, no abort) while any `irq_pend_i` bit is 1. A wait-for-event request is ignored while any `evt_pend_i` bit is 1. Interrupt pending bits do not block wait-for-event.
- R5: A stop request that would otherwise be taken while any `wk_flag_i` bit is 1 keeps the block running and raises `entry_abort_o` for exactly one cycle.
- R6: After entry by wait-for-interrupt or return-from-handler, stop ends only on a line i with `wk_line_i[i]`, `wk_int_mode_i[i]` and `irq_en_i[i]` all 1.
- R7: After entry by wait-for-event with `sev_pend_en_i`=0 (latched at entry), stop ends only on a line with `wk_line_i[i]` and `wk_evt_mode_i[i]` both 1.
- R8: After entry by wait-for-event with `sev_pend_en_i`=1, stop ends on any line with `wk_line_i[i]` and `wk_int_mode_i[i]` both 1, whatever `irq_en_i[i]` is.
- R9: In the cycle after a wakeup hit, `osc_off_o` is 0. `clk_stop_o` stays 1 until wakeup completes.
- R10: Wakeup completes only once `osc_rdy_i` has been seen and `flash_rdy_i` has been seen in the same cycle as, or after, `reg_rdy_i`. A flash ready that comes before any regulator ready does not count.
- R11: On completion `wake_done_o` is 1 for exactly one cycle, in the same cycle that `clk_stop_o` returns to 0.
- R12: A request taken with `deep_en_i`=0 or `mode_sel_i`≠3'b001 sets `sleep_o` with clocks and oscillators left on. It leaves on the same wakeup rule straight to run, with no `wake_done_o` pulse.
- R13: When strobes coincide, wait-for-interrupt wins over wait-for-event, which wins over return-from-handler. The winner sets both the blocking check and the exit rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wfi_i | input | 1 | Wait-for-interrupt strobe |
| wfe_i | input | 1 | Wait-for-event strobe |
| isr_ret_i | input | 1 | Return-from-handler strobe |
| deep_en_i | input | 1 | Deep-sleep enable from the core |
| exit_sleep_en_i | input | 1 | Sleep-on-exit enable |
| sev_pend_en_i | input | 1 | Send-event-on-pending enable |
| mode_sel_i | input | 3 | Low-power mode select; 3'b001 picks stop |
| irq_pend_i | input | N_IRQ | Pending interrupts |
| evt_pend_i | input | N_EVT | Pending events |
| wk_flag_i | input | N_WK | Wakeup pending bits and peripheral wakeup flags |
| wk_line_i | input | N_WK | Live wakeup line activity |
| wk_int_mode_i | input | N_WK | Line configured in interrupt mode |
| wk_evt_mode_i | input | N_WK | Line configured in event mode |
| irq_en_i | input | N_WK | Line interrupt enabled in the interrupt controller |
| osc_rdy_i | input | 1 | Oscillator ready |
| reg_rdy_i | input | 1 | Regulator ready |
| flash_rdy_i | input | 1 | Flash ready |
| clk_stop_o | output | 1 | Core-domain clock gate active |
| osc_off_o | output | 1 | PLL and main oscillators disabled |
| sleep_o | output | 1 | Plain sleep, clocks running |
| wake_done_o | output | 1 | One-cycle wakeup-complete pulse |
| entry_abort_o | output | 1 | One-cycle stop-entry rejection pulse |

## Verification
The hardest situation to reach is the ordering rule in wakeup completion. Flash ready must count only when it comes with or after regulator ready, while oscillator ready may come at any point. The stimulus enters stop, forces a wakeup, and then drives the three ready inputs one at a time in separate cycles: flash alone first, then oscillator, then regulator, then flash again. It checks that completion happens only on the last step. The three exit rules are separated by entering with each wait kind and first presenting lines the latched rule must ignore. The stimulus then presents the one line that rule accepts.

// File: rtl/lpc_pkg.sv
package lpc_pkg;
  typedef enum logic [1:0] {ST_RUN, ST_SLEEP, ST_STOP, ST_WAKE} lpc_state_e;
  typedef enum logic [1:0] {EK_INT, EK_EVT, EK_EVT_SEV} lpc_kind_e;
  localparam int unsigned MODE_W = 3;
  localparam logic [MODE_W-1:0] MODE_STOP = 3'b001;
endpackage

// File: rtl/lpc_entry_qual.sv
module lpc_entry_qual
  import lpc_pkg::*;
#(
  parameter int unsigned N_IRQ = 8,
  parameter int unsigned N_EVT = 4,
  parameter int unsigned N_WK  = 8
) (
  input  logic              wfi_i,
  input  logic              wfe_i,
  input  logic              isr_ret_i,
  input  logic              deep_en_i,
  input  logic              exit_sleep_en_i,
  input  logic              sev_pend_en_i,
  input  logic [MODE_W-1:0] mode_sel_i,
  input  logic [N_IRQ-1:0]  irq_pend_i,
  input  logic [N_EVT-1:0]  evt_pend_i,
  input  logic [N_WK-1:0]   wk_flag_i,
  output lpc_kind_e         kind_o,
  output logic              go_stop_o,
  output logic              go_sleep_o,
  output logic              abort_o
);
  logic has_req, blocked, stop_sel, ok;

  // Strobe priority: WFI, then WFE, then handler return (R13)
  always_comb begin
    has_req = 1'b0;
    kind_o  = EK_INT;
    if (wfi_i) begin
      has_req = 1'b1;
      kind_o  = EK_INT;
    end else if (wfe_i) begin
      has_req = 1'b1;
      kind_o  = sev_pend_en_i ? EK_EVT_SEV : EK_EVT;
    end else if (isr_ret_i && exit_sleep_en_i) begin
      has_req = 1'b1;
      kind_o  = EK_INT;
    end
  end

  assign blocked    = (kind_o == EK_INT) ? (|irq_pend_i) : (|evt_pend_i);
  assign stop_sel   = deep_en_i && (mode_sel_i == MODE_STOP);
  assign ok         = has_req && !blocked;
  assign abort_o    = ok && stop_sel && (|wk_flag_i);
  assign go_stop_o  = ok && stop_sel && !(|wk_flag_i);
  assign go_sleep_o = ok && !stop_sel;
endmodule

// File: rtl/lpc_wake_sel.sv
module lpc_wake_sel
  import lpc_pkg::*;
#(
  parameter int unsigned N_WK = 8
) (
  input  lpc_kind_e       kind_i,
  input  logic [N_WK-1:0] wk_line_i,
  input  logic [N_WK-1:0] wk_int_mode_i,
  input  logic [N_WK-1:0] wk_evt_mode_i,
  input  logic [N_WK-1:0] irq_en_i,
  output logic            hit_o
);
  logic [N_WK-1:0] line_ok;

  for (genvar i = 0; i < N_WK; i++) begin : g_line
    always_comb begin
      unique case (kind_i)
        EK_EVT:     line_ok[i] = wk_line_i[i] && wk_evt_mode_i[i];
        EK_EVT_SEV: line_ok[i] = wk_line_i[i] && wk_int_mode_i[i];
        default:    line_ok[i] = wk_line_i[i] && wk_int_mode_i[i] && irq_en_i[i];
      endcase
    end
  end

  assign hit_o = |line_ok;
endmodule

// File: rtl/lpc_rdy_track.sv
module lpc_rdy_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic osc_rdy_i,
  input  logic reg_rdy_i,
  input  logic flash_rdy_i,
  output logic all_o
);
  logic osc_seen, reg_seen, flash_seen;
  logic osc_ok, reg_ok, flash_ok;

  assign osc_ok   = osc_seen || osc_rdy_i;
  assign reg_ok   = reg_seen || reg_rdy_i;
  assign flash_ok = flash_seen || (flash_rdy_i && reg_ok);
  assign all_o    = active_i && osc_ok && flash_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      osc_seen   <= 1'b0;
      reg_seen   <= 1'b0;
      flash_seen <= 1'b0;
    end else if (!active_i) begin
      osc_seen   <= 1'b0;
      reg_seen   <= 1'b0;
      flash_seen <= 1'b0;
    end else begin
      osc_seen   <= osc_ok;
      reg_seen   <= reg_ok;
      flash_seen <= flash_ok;
    end
  end
endmodule

// File: rtl/lpc_ctrl.sv
module lpc_ctrl
  import lpc_pkg::*;
#(
  parameter int unsigned N_IRQ = 8,
  parameter int unsigned N_EVT = 4,
  parameter int unsigned N_WK  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wfi_i,
  input  logic              wfe_i,
  input  logic              isr_ret_i,
  input  logic              deep_en_i,
  input  logic              exit_sleep_en_i,
  input  logic              sev_pend_en_i,
  input  logic [2:0]        mode_sel_i,
  input  logic [N_IRQ-1:0]  irq_pend_i,
  input  logic [N_EVT-1:0]  evt_pend_i,
  input  logic [N_WK-1:0]   wk_flag_i,
  input  logic [N_WK-1:0]   wk_line_i,
  input  logic [N_WK-1:0]   wk_int_mode_i,
  input  logic [N_WK-1:0]   wk_evt_mode_i,
  input  logic [N_WK-1:0]   irq_en_i,
  input  logic              osc_rdy_i,
  input  logic              reg_rdy_i,
  input  logic              flash_rdy_i,
  output logic              clk_stop_o,
  output logic              osc_off_o,
  output logic              sleep_o,
  output logic              wake_done_o,
  output logic              entry_abort_o
);
  lpc_state_e state_q, state_d;
  lpc_kind_e  kind_q, kind_new;
  logic       go_stop, go_sleep, abort_req, wake_hit, rdy_all;
  logic       done_q, abort_q;

  lpc_entry_qual #(.N_IRQ(N_IRQ), .N_EVT(N_EVT), .N_WK(N_WK)) u_qual (
    .wfi_i(wfi_i), .wfe_i(wfe_i), .isr_ret_i(isr_ret_i),
    .deep_en_i(deep_en_i), .exit_sleep_en_i(exit_sleep_en_i),
    .sev_pend_en_i(sev_pend_en_i), .mode_sel_i(mode_sel_i),
    .irq_pend_i(irq_pend_i), .evt_pend_i(evt_pend_i), .wk_flag_i(wk_flag_i),
    .kind_o(kind_new), .go_stop_o(go_stop), .go_sleep_o(go_sleep),
    .abort_o(abort_req)
  );

  lpc_wake_sel #(.N_WK(N_WK)) u_wsel (
    .kind_i(kind_q), .wk_line_i(wk_line_i), .wk_int_mode_i(wk_int_mode_i),
    .wk_evt_mode_i(wk_evt_mode_i), .irq_en_i(irq_en_i), .hit_o(wake_hit)
  );

  lpc_rdy_track u_rdy (
    .clk_i(clk_i), .rst_ni(rst_ni), .active_i(state_q == ST_WAKE),
    .osc_rdy_i(osc_rdy_i), .reg_rdy_i(reg_rdy_i), .flash_rdy_i(flash_rdy_i),
    .all_o(rdy_all)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN: begin
        if (go_stop)       state_d = ST_STOP;
        else if (go_sleep) state_d = ST_SLEEP;
      end
      ST_SLEEP: if (wake_hit) state_d = ST_RUN;
      ST_STOP:  if (wake_hit) state_d = ST_WAKE;
      ST_WAKE:  if (rdy_all)  state_d = ST_RUN;
      default:  state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      kind_q  <= EK_INT;
      done_q  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_RUN && (go_stop || go_sleep)) kind_q <= kind_new;
      done_q  <= (state_q == ST_WAKE) && rdy_all;
      abort_q <= (state_q == ST_RUN) && abort_req;
    end
  end

  assign clk_stop_o    = (state_q == ST_STOP) || (state_q == ST_WAKE);
  assign osc_off_o     = (state_q == ST_STOP);
  assign sleep_o       = (state_q == ST_SLEEP);
  assign wake_done_o   = done_q;
  assign entry_abort_o = abort_q;
endmodule

// File: rtl/lpc_ctrl_chk.sv
module lpc_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       deep_en_i,
  input logic [2:0] mode_sel_i,
  input logic       clk_stop_o,
  input logic       osc_off_o,
  input logic       sleep_o,
  input logic       wake_done_o,
  input logic       entry_abort_o
);
  a_r2_stop_needs_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(osc_off_o) |-> $past(deep_en_i && mode_sel_i == 3'b001));
  a_r5_abort_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_abort_o |-> !clk_stop_o && !sleep_o);
  a_r9_osc_off_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osc_off_o |-> clk_stop_o);
  a_r11_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_done_o |=> !wake_done_o);
  a_r11_done_clocks_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_done_o |-> !clk_stop_o && !osc_off_o && $past(clk_stop_o));
  a_r12_sleep_clocks_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_o |-> !clk_stop_o && !osc_off_o);
endmodule

bind lpc_ctrl lpc_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .deep_en_i(deep_en_i), .mode_sel_i(mode_sel_i),
  .clk_stop_o(clk_stop_o), .osc_off_o(osc_off_o), .sleep_o(sleep_o),
  .wake_done_o(wake_done_o), .entry_abort_o(entry_abort_o)
);

// File: tb/lpc_ctrl_tb_top.sv
`timescale 1ns/1ps
module lpc_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wfi = 0, wfe = 0, isr_ret = 0, deep_en = 0, exit_en = 0, sev_en = 0;
  logic [2:0] mode_sel = 3'b000;
  logic [7:0] irq_pend = '0;
  logic [3:0] evt_pend = '0;
  logic [7:0] wk_flag = '0, wk_line = '0, int_mode = '0, evt_mode = '0, irq_en = '0;
  logic osc_rdy = 0, reg_rdy = 0, flash_rdy = 0;
  logic clk_stop, osc_off, sleep_st, wake_done, abort_p;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  lpc_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wfi_i(wfi), .wfe_i(wfe), .isr_ret_i(isr_ret),
    .deep_en_i(deep_en), .exit_sleep_en_i(exit_en), .sev_pend_en_i(sev_en),
    .mode_sel_i(mode_sel), .irq_pend_i(irq_pend), .evt_pend_i(evt_pend),
    .wk_flag_i(wk_flag), .wk_line_i(wk_line), .wk_int_mode_i(int_mode),
    .wk_evt_mode_i(evt_mode), .irq_en_i(irq_en), .osc_rdy_i(osc_rdy),
    .reg_rdy_i(reg_rdy), .flash_rdy_i(flash_rdy), .clk_stop_o(clk_stop),
    .osc_off_o(osc_off), .sleep_o(sleep_st), .wake_done_o(wake_done),
    .entry_abort_o(abort_p)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // state code: {clk_stop, osc_off, sleep}
  function automatic int st();
    return {29'd0, clk_stop, osc_off, sleep_st};
  endfunction

  task automatic pulse_wfi();
    wfi = 1; step(); wfi = 0;
  endtask
  task automatic pulse_wfe();
    wfe = 1; step(); wfe = 0;
  endtask

  task automatic line_pulse(input logic [7:0] l);
    wk_line = l; step(); wk_line = '0;
  endtask

  task automatic finish_wake(input string req);
    osc_rdy = 1; reg_rdy = 1; flash_rdy = 1; step();
    osc_rdy = 0; reg_rdy = 0; flash_rdy = 0;
    chk(req, "done pulse", wake_done, 1);
    chk(req, "clocks back", st(), 0);
    step();
    chk(req, "done one cycle", wake_done, 0);
  endtask

  task automatic t_reset();
    chk("R1", "state after reset", st(), 0);
    chk("R1", "done after reset", wake_done, 0);
    chk("R1", "abort after reset", abort_p, 0);
  endtask

  task automatic t_wfi_stop();
    deep_en = 1; mode_sel = 3'b001;
    int_mode = 8'h04; irq_en = 8'h00;
    pulse_wfi();
    chk("R2", "stop entered", st(), 6);
    line_pulse(8'h04);
    chk("R6", "disabled irq ignored", st(), 6);
    irq_en = 8'h04;
    line_pulse(8'h04);
    chk("R9", "osc on in wake", st(), 4);
    flash_rdy = 1; step(); flash_rdy = 0;
    chk("R10", "flash before reg ignored", st(), 4);
    osc_rdy = 1; step(); osc_rdy = 0;
    chk("R10", "osc alone not enough", st(), 4);
    reg_rdy = 1; step(); reg_rdy = 0;
    chk("R10", "reg without flash", st(), 4);
    flash_rdy = 1; step(); flash_rdy = 0;
    chk("R11", "done after flash", wake_done, 1);
    chk("R11", "clocks on", st(), 0);
    step();
    chk("R11", "single pulse", wake_done, 0);
    int_mode = '0; irq_en = '0;
  endtask

  task automatic t_isr();
    exit_en = 0;
    isr_ret = 1; step(); isr_ret = 0;
    chk("R3", "ret without exit enable", st(), 0);
    exit_en = 1;
    isr_ret = 1; step(); isr_ret = 0;
    chk("R3", "ret enters stop", st(), 6);
    int_mode = 8'h10; irq_en = 8'h10;
    line_pulse(8'h10);
    chk("R6", "int line wakes", st(), 4);
    finish_wake("R3");
    exit_en = 0; int_mode = '0; irq_en = '0;
  endtask

  task automatic t_blocked();
    irq_pend = 8'h01;
    pulse_wfi();
    chk("R4", "wfi blocked by irq", st(), 0);
    chk("R4", "no abort when blocked", abort_p, 0);
    irq_pend = '0; evt_pend = 4'h2;
    pulse_wfe();
    chk("R4", "wfe blocked by event", st(), 0);
    evt_pend = '0; irq_pend = 8'h01;
    pulse_wfe();
    chk("R4", "wfe ignores irq pending", st(), 6);
    irq_pend = '0;
    evt_mode = 8'h01;
    line_pulse(8'h01);
    chk("R7", "event line wakes", st(), 4);
    finish_wake("R4");
    evt_mode = '0;
  endtask

  task automatic t_abort();
    wk_flag = 8'h80;
    pulse_wfi();
    wk_flag = '0;
    chk("R5", "abort pulse", abort_p, 1);
    chk("R5", "still running", st(), 0);
    step();
    chk("R5", "abort one cycle", abort_p, 0);
  endtask

  task automatic t_wfe_nosev();
    sev_en = 0;
    pulse_wfe();
    sev_en = 1;
    chk("R7", "stop via wfe", st(), 6);
    int_mode = 8'h02; irq_en = 8'h02;
    line_pulse(8'h02);
    chk("R7", "int line ignored", st(), 6);
    evt_mode = 8'h08;
    line_pulse(8'h08);
    chk("R7", "event line wakes", st(), 4);
    finish_wake("R7");
    int_mode = '0; irq_en = '0; evt_mode = '0; sev_en = 0;
  endtask

  task automatic t_wfe_sev();
    sev_en = 1;
    pulse_wfe();
    sev_en = 0;
    chk("R8", "stop via wfe sev", st(), 6);
    evt_mode = 8'h20;
    line_pulse(8'h20);
    chk("R8", "event-only line ignored", st(), 6);
    int_mode = 8'h40; irq_en = 8'h00;
    line_pulse(8'h40);
    chk("R8", "disabled int line wakes", st(), 4);
    finish_wake("R8");
    int_mode = '0; evt_mode = '0;
  endtask

  task automatic t_sleep();
    mode_sel = 3'b010;
    pulse_wfi();
    chk("R12", "plain sleep", st(), 1);
    int_mode = 8'h01; irq_en = 8'h01;
    line_pulse(8'h01);
    chk("R12", "back to run", st(), 0);
    chk("R12", "no done pulse", wake_done, 0);
    mode_sel = 3'b001; deep_en = 0;
    pulse_wfi();
    chk("R12", "sleep without deep", st(), 1);
    line_pulse(8'h01);
    chk("R12", "run again", st(), 0);
    deep_en = 1; int_mode = '0; irq_en = '0;
  endtask

  task automatic t_priority();
    evt_pend = 4'h1; sev_en = 0;
    wfi = 1; wfe = 1; step(); wfi = 0; wfe = 0;
    evt_pend = '0;
    chk("R13", "wfi wins over wfe", st(), 6);
    evt_mode = 8'h01;
    line_pulse(8'h01);
    chk("R13", "wfi exit rule kept", st(), 6);
    int_mode = 8'h01; irq_en = 8'h01;
    line_pulse(8'h01);
    chk("R13", "int line wakes", st(), 4);
    finish_wake("R13");
    evt_mode = '0; int_mode = '0; irq_en = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    step(); step();
    t_reset();
    rst_n = 1;
    step();
    t_reset();
    t_wfi_stop();
    t_isr();
    t_blocked();
    t_abort();
    t_wfe_nosev();
    t_wfe_sev();
    t_sleep();
    t_priority();
    step();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule